// File: doc/BRIEF.md
# Self-Calibrating Sliding-Average Threshold Detector

This block watches a stream of 10-bit unsigned converter samples. Each sample arrives with a one-cycle valid strobe, at a nominal rate of 200 ksps. After reset it first spends a fixed number of samples learning the quiet background. It accumulates the sum and the sum of squares of those samples, and from them it derives the background mean and, using a sequential integer square root, the standard deviation. The trigger level is the mean plus three deviations, clipped to the 10-bit range.

Once calibrated, the block averages the 16 most recent samples in a sliding window and compares that average with the learned level. A hysteresis band on either side of the level keeps the output from toggling on marginal signals. The block drives a detect level and a single-cycle event on each rising edge of detect, which suits an interrupt request. A synchronous restart input drops all learned state and starts the calibration again.

Top module: `cal_avg_detector`

## Requirements
- R1: While rst_n is low, detect, detect_evt, cal_done, baseline and threshold are all zero.
- R2: Calibration uses the first CAL_LEN (default 2000) valid samples after reset or restart. baseline = floor(S/CAL_LEN), where S is the sum of those samples.
- R3: threshold = min(1023, baseline + 3*floor(sqrt(V))), where V = max(0, floor(Q/CAL_LEN) - baseline^2) and Q is the sum of squares of the calibration samples. baseline and threshold stay constant until the next restart.
- R4: cal_done rises no more than 16 clock cycles after the last calibration sample. detect is low whenever cal_done is low.
- R5: The working average is floor(sum of the 16 most recently accepted samples / 16). Samples count as accepted only while cal_done is high. detect stays low until 16 samples have been accepted.
- R6: detect is set when the average is greater than threshold + HYST (default 3).
- R7: detect is cleared when average + HYST is less than threshold. When the average lies inside the band, detect holds its value.
- R8: detect_evt is high for exactly the one cycle in which detect first reads high after being low, and it is low at all other times.
- R9: A high restart_cal on a clock edge clears cal_done, detect, baseline, threshold and the window, then begins a new calibration.
- R10: detect reflects a newly accepted sample two clock edges after the edge that takes the sample.
- R11: If baseline + 3*sigma exceeds 1023, threshold is 1023, so detect can never be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_cal | input | 1 | Synchronous request to clear state and recalibrate |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 10 | Unsigned sample value |
| detect | output | 1 | Detection level with hysteresis |
| detect_evt | output | 1 | One-cycle pulse on each rising edge of detect |
| cal_done | output | 1 | Calibration and deviation computation complete |
| baseline | output | 10 | Learned background mean |
| threshold | output | 10 | Learned trigger level, saturated |

## Verification
The properties check on every cycle that detect stays low before calibration completes and that the event pulse matches each rising edge of detect exactly. They also check that a restart clears the done flag and detect, and that the learned level stays fixed and never falls below the baseline once calibration is done. Only the bench scenarios can show the arithmetic of the learned values: the mean, the floored square-root deviation and the saturation. The same holds for the fill-up delay of the window and for where the hysteresis band actually switches detect; the bench checks these against a sample-by-sample model fed with random background noise, bursts, and constant levels placed on and just beyond the band edges.

// File: rtl/cal_avg_detector.sv
module cal_avg_detector #(
  parameter int DW       = 10,
  parameter int WIN_LOG2 = 4,
  parameter int CAL_LEN  = 2000,
  parameter int SIGMA_K  = 3,
  parameter int HYST     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_cal,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          detect,
  output logic          detect_evt,
  output logic          cal_done,
  output logic [DW-1:0] baseline,
  output logic [DW-1:0] threshold
);
  localparam int WIN   = 1 << WIN_LOG2;
  localparam int MAXV  = (1 << DW) - 1;
  localparam int SUM_W = $clog2(longint'(CAL_LEN) * MAXV + 1);
  localparam int SQ_W  = $clog2(longint'(CAL_LEN) * MAXV * MAXV + 1);
  localparam int VW    = 2 * DW;
  localparam int CW    = $clog2(CAL_LEN + 1);
  localparam int BW    = $clog2(DW);
  localparam int AW    = DW + WIN_LOG2;
  localparam int TW    = DW + $clog2(SIGMA_K + 2);
  localparam int XW    = DW + 2;

  typedef enum logic [1:0] {S_CAL, S_ROOT, S_RUN} st_t;

  st_t                st;
  logic [CW-1:0]      cal_cnt;
  logic [SUM_W-1:0]   sum_q;
  logic [SQ_W-1:0]    sq_q;
  logic [DW-1:0]      root;
  logic [BW-1:0]      bit_i;
  logic [DW-1:0]      win [WIN];
  logic [AW-1:0]      wsum;
  logic [WIN_LOG2:0]  fill;
  logic               det_q, det_d;

  wire [DW-1:0] mean_v   = DW'(sum_q / SUM_W'(CAL_LEN));
  wire [VW-1:0] ex2_v    = VW'(sq_q / SQ_W'(CAL_LEN));
  wire [VW-1:0] msq      = VW'(mean_v) * VW'(mean_v);
  wire [VW-1:0] var_v    = (ex2_v > msq) ? ex2_v - msq : '0;
  wire [DW-1:0] trial    = root | (DW'(1) << bit_i);
  wire [VW-1:0] trial_sq = VW'(trial) * VW'(trial);
  wire [DW-1:0] root_nx  = (trial_sq <= var_v) ? trial : root;
  wire [TW-1:0] thr_full = TW'(mean_v) + TW'(SIGMA_K) * TW'(root_nx);
  wire [VW-1:0] smp_sq   = VW'(smp_data) * VW'(smp_data);
  wire [XW-1:0] avg_x    = XW'(wsum >> WIN_LOG2);
  wire [XW-1:0] thr_x    = XW'(threshold);
  wire          win_full = (fill == (WIN_LOG2+1)'(WIN));

  assign cal_done   = (st == S_RUN);
  assign detect     = det_q;
  assign detect_evt = det_q & ~det_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CAL; cal_cnt <= '0; sum_q <= '0; sq_q <= '0;
      root <= '0; bit_i <= '0; wsum <= '0; fill <= '0;
      det_q <= 1'b0; det_d <= 1'b0; baseline <= '0; threshold <= '0;
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else if (restart_cal) begin
      st <= S_CAL; cal_cnt <= '0; sum_q <= '0; sq_q <= '0;
      root <= '0; bit_i <= '0; wsum <= '0; fill <= '0;
      det_q <= 1'b0; det_d <= 1'b0; baseline <= '0; threshold <= '0;
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else begin
      det_d <= det_q;
      case (st)
        S_CAL: if (smp_valid) begin
          sum_q   <= sum_q + SUM_W'(smp_data);
          sq_q    <= sq_q + SQ_W'(smp_sq);
          cal_cnt <= cal_cnt + 1'b1;
          if (cal_cnt == CW'(CAL_LEN - 1)) begin
            st    <= S_ROOT;
            root  <= '0;
            bit_i <= BW'(DW - 1);
          end
        end
        S_ROOT: begin
          root  <= root_nx;
          bit_i <= bit_i - 1'b1;
          if (bit_i == '0) begin
            st        <= S_RUN;
            baseline  <= mean_v;
            threshold <= (thr_full > TW'(MAXV)) ? DW'(MAXV) : DW'(thr_full);
          end
        end
        default: begin
          if (smp_valid) begin
            win[0] <= smp_data;
            for (int i = 1; i < WIN; i++) win[i] <= win[i-1];
            wsum <= wsum + AW'(smp_data) - AW'(win[WIN-1]);
            if (!win_full) fill <= fill + 1'b1;
          end
          if (win_full) begin
            if (avg_x > thr_x + XW'(HYST))      det_q <= 1'b1;
            else if (avg_x + XW'(HYST) < thr_x) det_q <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cal_avg_detector_chk.sv
module cal_avg_detector_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart_cal,
  input logic          detect,
  input logic          detect_evt,
  input logic          cal_done,
  input logic [DW-1:0] baseline,
  input logic [DW-1:0] threshold
);
  // R4
  gate_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> !detect);

  // R8
  evt_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect_evt |-> (detect && !$past(detect)));

  // R8
  evt_on_every_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect) |-> detect_evt);

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cal |=> (!cal_done && !detect && threshold == '0));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !restart_cal) |=> cal_done);

  // R3
  level_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !restart_cal) |=> ($stable(threshold) && $stable(baseline)));

  // R11
  level_above_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (threshold >= baseline));
endmodule

bind cal_avg_detector cal_avg_detector_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart_cal(restart_cal), .detect(detect),
  .detect_evt(detect_evt), .cal_done(cal_done), .baseline(baseline),
  .threshold(threshold)
);

// File: tb/cal_avg_detector_tb.sv
module cal_avg_detector_tb;
  localparam int N = 2000;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_cal = 1'b0;
  logic smp_valid = 1'b0;
  logic [9:0] smp_data = '0;
  logic detect, detect_evt, cal_done;
  logic [9:0] baseline, threshold;

  int total = 0;
  int bad = 0;
  int exp_base, exp_thr;
  int q[$];
  bit det_m;
  int seed_dummy;

  always #4 clk = ~clk;

  cal_avg_detector u_dut (
    .clk(clk), .rst_n(rst_n), .restart_cal(restart_cal), .smp_valid(smp_valid),
    .smp_data(smp_data), .detect(detect), .detect_evt(detect_evt),
    .cal_done(cal_done), .baseline(baseline), .threshold(threshold)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int isqrt(input longint v);
    int r = 0;
    for (int b = 9; b >= 0; b--) begin
      int t = r | (1 << b);
      if (longint'(t) * t <= v) r = t;
    end
    return r;
  endfunction

  task automatic send(input int v);
    smp_valid = 1'b1;
    smp_data = 10'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic calibrate(input int mode);
    longint s = 0, sq = 0, ex2, vr;
    int v, m, t, w;
    for (int i = 0; i < N; i++) begin
      if (mode == 0) v = 100 + int'($urandom % 21);
      else v = ($urandom % 2) ? 1023 : 0;
      s += v; sq += longint'(v) * v;
      send(v);
      if (i % 250 == 0) begin
        chk("R4 done low in cal", cal_done, 0);
        chk("R4 detect low in cal", detect, 0);
      end
      @(negedge clk);
    end
    w = 0;
    while (!cal_done && w < 20) begin @(negedge clk); w++; end
    chk("R4 done latency", (cal_done && w <= 16) ? 1 : 0, 1);
    m = int'(s / N);
    ex2 = sq / N;
    vr = (ex2 > longint'(m) * m) ? ex2 - longint'(m) * m : 0;
    t = m + 3 * isqrt(vr);
    if (t > 1023) t = 1023;
    exp_base = m; exp_thr = t;
    chk("R2 baseline", baseline, exp_base);
    chk("R3 threshold", threshold, exp_thr);
    q.delete();
    det_m = 1'b0;
  endtask

  task automatic run(input int v);
    bit prev = det_m;
    int s = 0;
    q.push_front(v);
    if (q.size() > 16) void'(q.pop_back());
    if (q.size() == 16) begin
      foreach (q[k]) s += q[k];
      s = s / 16;
      if (s > exp_thr + H) det_m = 1'b1;
      else if (s + H < exp_thr) det_m = 1'b0;
    end
    send(v);
    if (q.size() < 16) chk("R5 window filling", detect, 0);
    else if (det_m && !prev) chk("R6 R10 set", detect, 1);
    else if (!det_m && prev) chk("R7 R10 clear", detect, 0);
    else chk("R5 R7 hold", detect, int'(det_m));
    chk("R8 event", detect_evt, int'(det_m && !prev));
    @(negedge clk);
  endtask

  initial begin
    seed_dummy = $urandom(32'h1d3c);
    repeat (3) @(negedge clk);
    chk("R1 detect", detect, 0);
    chk("R1 evt", detect_evt, 0);
    chk("R1 done", cal_done, 0);
    chk("R1 baseline", baseline, 0);
    chk("R1 threshold", threshold, 0);
    rst_n = 1'b1;
    @(negedge clk);

    calibrate(0);
    for (int i = 0; i < 15; i++) run(400);
    run(400);
    for (int i = 0; i < 30; i++) run(100 + int'($urandom % 21));
    for (int i = 0; i < 20; i++) run(200 + int'($urandom % 41));
    for (int i = 0; i < 20; i++) run(exp_thr);
    for (int i = 0; i < 20; i++) run(exp_thr - H);
    for (int i = 0; i < 20; i++) run(exp_thr - H - 1);
    for (int i = 0; i < 20; i++) run(exp_thr + H);
    for (int i = 0; i < 20; i++) run(exp_thr + H + 1);
    for (int i = 0; i < 20; i++) run(exp_thr);
    for (int i = 0; i < 60; i++) run(exp_thr - 8 + int'($urandom % 17));
    for (int i = 0; i < 20; i++) run(500);

    restart_cal = 1'b1;
    @(negedge clk);
    restart_cal = 1'b0;
    chk("R9 done cleared", cal_done, 0);
    chk("R9 detect cleared", detect, 0);
    chk("R9 baseline cleared", baseline, 0);
    chk("R9 threshold cleared", threshold, 0);

    calibrate(1);
    chk("R11 saturated", threshold, 1023);
    for (int i = 0; i < 30; i++) run(1023);
    chk("R11 never set", detect, 0);

    restart_cal = 1'b1;
    @(negedge clk);
    restart_cal = 1'b0;
    calibrate(0);
    for (int i = 0; i < 40; i++) run(($urandom % 3 == 0) ? 300 : 110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule